// File: doc/BRIEF.md
# PWM Input Activity Watchdog

This block watches the PWM lines that drive the two half-bridges of a power stage and decides whether they carry usable switching. Each line passes through its own synchronizer. It then has its own idle counter and its own low-pulse meter, so a line frozen high or frozen low is caught by itself. A single frozen line is enough to raise the shared inactivity flag. A frame whose low phase is too narrow is flagged at once, without waiting for any timeout.

The timeout is a run-time input counted in clock cycles. The integrator sets it to match the intended idle window, for example 650 cycles for 13 µs at 50 MHz. The minimum legal low phase is a build parameter in cycles. It must cover the 50 ns minimum low pulse at the chosen clock. Valid frames run between 192 kHz and 384 kHz, so the timeout must be longer than the longest legal high or low phase.

The flag does not latch. It comes out of reset set. It clears as soon as every channel has toggled since the most recent cycle in which any channel reported a fault.

Top module: `pwm_idle_guard`

## Requirements
- R1: During and directly after reset, `idle_flag` is 1, and `ch_stuck` and `ch_short_low` are all 0.
- R2: Each channel has its own idle check. After a PWM line changes level, its `ch_stuck` bit goes to 1 only if the line then holds that level, high or low, for `timeout_cyc`+2 or more consecutive clock samples. It stays 0 when the line holds for `timeout_cyc`+1 samples or fewer. A frozen line never sets the `ch_stuck` bit of another channel.
- R3: `timeout_cyc` is read every cycle, so a new value takes effect while the block runs. Values of 4 and above are supported.
- R4: Whenever any `ch_stuck` bit is 1, `idle_flag` is 1 in the following cycle.
- R5: A low phase shorter than `MIN_LOW_CYC` samples counts as a short low phase. It must lie between a falling edge and the next rising edge of a line. On such a phase, that channel's `ch_short_low` bit pulses high for exactly one cycle, and `idle_flag` is 1 in the following cycle. There is no timeout delay.
- R6: A low phase of exactly `MIN_LOW_CYC` samples is valid. It raises neither `ch_short_low` nor `idle_flag`.
- R7: The flag does not latch. Once no channel reports a fault, `idle_flag` returns to 0 after every channel has shown at least one edge since the last fault cycle. While any channel has not yet toggled, the flag stays at 1.
- R8: A `ch_stuck` bit returns to 0 once its line toggles again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | NUM_CH | Asynchronous PWM lines, one per half-bridge |
| timeout_cyc | input | CNT_W | Idle limit in clock cycles |
| idle_flag | output | 1 | Combined inactivity or invalid-frame flag |
| ch_stuck | output | NUM_CH | Per-channel frozen-line status |
| ch_short_low | output | NUM_CH | Per-channel one-cycle pulse on a short low phase |

## Verification
The bench builds the block with two channels, a 12-bit counter and a 3-cycle minimum low phase. It drives the timeout at 650 cycles, which is the 13 µs window at 50 MHz. At that value, holds of 651 and 652 samples fall on either side of the idle boundary, and low glitches of 2 and 3 samples fall on either side of the pulse boundary. Switching the timeout to 40 cycles at run time makes ordinary frames at 192 to 384 kHz look idle, which shows that the limit is taken live. Random frame periods, duty cycles, hold lengths and glitch widths then exercise both channels independently, and every trial ends with a check that the flag has recovered.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;

  // Per-channel report handed from a channel monitor to the flag controller.
  typedef struct packed {
    logic toggled;    // synchronized level changed this cycle
    logic stuck;      // no change for longer than the idle limit
    logic short_low;  // one-cycle pulse: last low phase was too narrow
  } mon_status_t;

endpackage

// File: rtl/pwm_guard_sync.sv
module pwm_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

endmodule

// File: rtl/pwm_guard_chan.sv
module pwm_guard_chan
  import pwm_guard_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_LOW_CYC = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwm_raw,
  input  logic [CNT_W-1:0] timeout_cyc,
  output mon_status_t      status
);

  localparam int LOW_W = $clog2(MIN_LOW_CYC + 1);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(MIN_LOW_CYC);

  logic             lvl, lvl_d;
  logic             chg, rise, fall;
  logic [CNT_W-1:0] idle_cnt;
  logic [LOW_W-1:0] low_cnt;
  logic             fall_seen;
  logic             stuck_q, short_q;

  pwm_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwm_raw),
    .q   (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign chg  = lvl ^ lvl_d;
  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  // Idle counter: restarts on every synchronized edge, saturates at the limit.
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      stuck_q  <= 1'b0;
    end else begin
      if (chg)                        idle_cnt <= '0;
      else if (idle_cnt < timeout_cyc) idle_cnt <= idle_cnt + CNT_W'(1);
      stuck_q <= !chg && (idle_cnt >= timeout_cyc);
    end
  end

  // Low-phase meter: counts low samples from a falling edge, judged on the rise.
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt   <= LOW_MAX;
      fall_seen <= 1'b0;
      short_q   <= 1'b0;
    end else begin
      if (fall) begin
        low_cnt   <= LOW_W'(1);
        fall_seen <= 1'b1;
      end else if (!lvl && low_cnt < LOW_MAX) begin
        low_cnt <= low_cnt + LOW_W'(1);
      end
      short_q <= rise && fall_seen && (low_cnt < LOW_MAX);
    end
  end

  assign status = '{toggled: chg, stuck: stuck_q, short_low: short_q};

endmodule

// File: rtl/pwm_guard_flag.sv
module pwm_guard_flag #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] toggled,
  input  logic [NUM_CH-1:0] stuck,
  input  logic [NUM_CH-1:0] short_low,
  output logic              flag
);

  logic              trip;
  logic [NUM_CH-1:0] seen_q;
  logic [NUM_CH-1:0] seen_now;
  logic              flag_q;

  assign trip     = (|stuck) | (|short_low);
  assign seen_now = seen_q | toggled;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b1;
      seen_q <= '0;
    end else if (trip) begin
      flag_q <= 1'b1;
      seen_q <= toggled;
    end else begin
      seen_q <= seen_now;
      if (&seen_now) flag_q <= 1'b0;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/pwm_idle_guard.sv
module pwm_idle_guard
  import pwm_guard_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 16,
  parameter int MIN_LOW_CYC = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pwm_in,
  input  logic [CNT_W-1:0]  timeout_cyc,
  output logic              idle_flag,
  output logic [NUM_CH-1:0] ch_stuck,
  output logic [NUM_CH-1:0] ch_short_low
);

  logic [NUM_CH-1:0] toggled_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mon_status_t st;

    pwm_guard_chan #(
      .CNT_W       (CNT_W),
      .MIN_LOW_CYC (MIN_LOW_CYC),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_chan (
      .clk         (clk),
      .rst         (rst),
      .pwm_raw     (pwm_in[i]),
      .timeout_cyc (timeout_cyc),
      .status      (st)
    );

    assign toggled_v[i]    = st.toggled;
    assign ch_stuck[i]     = st.stuck;
    assign ch_short_low[i] = st.short_low;
  end

  pwm_guard_flag #(.NUM_CH(NUM_CH)) u_flag (
    .clk       (clk),
    .rst       (rst),
    .toggled   (toggled_v),
    .stuck     (ch_stuck),
    .short_low (ch_short_low),
    .flag      (idle_flag)
  );

endmodule

// File: rtl/pwm_idle_guard_chk.sv
module pwm_idle_guard_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] pwm_in,
  input logic              idle_flag,
  input logic [NUM_CH-1:0] ch_stuck,
  input logic [NUM_CH-1:0] ch_short_low
);

  // R4: a frozen channel forces the shared flag on the next cycle.
  assert_stuck_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (|ch_stuck) |=> idle_flag);

  // R5: a short low phase forces the flag on the next cycle, no timeout.
  assert_short_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (|ch_short_low) |=> idle_flag);

  // R7: the flag only comes back on after a reported fault.
  assert_flag_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_flag) |-> $past((|ch_stuck) || (|ch_short_low)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R5: the short-low report is a single-cycle pulse.
    assert_short_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
      ch_short_low[i] |=> !ch_short_low[i]);

    // R2: a channel can only be declared frozen while its line is steady.
    assert_stuck_input_stable_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_stuck[i]) |-> $stable(pwm_in[i]));
  end

endmodule

bind pwm_idle_guard pwm_idle_guard_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/pwm_idle_guard_tb_top.sv
module pwm_idle_guard_tb_top;

  localparam int NCH   = 2;
  localparam int CW    = 12;
  localparam int ML    = 3;
  localparam int T_NOM = 650;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst;
  logic [NCH-1:0]  pwm_in;
  logic [CW-1:0]   timeout_cyc;
  logic            idle_flag;
  logic [NCH-1:0]  ch_stuck, ch_short_low;

  int errors = 0;
  int checks = 0;

  // Frame generators, one per channel, stepped at the falling clock edge.
  int per  [NCH] = '{200, 170};
  int lowl [NCH] = '{100, 60};
  int ph   [NCH] = '{0, 37};
  logic [NCH-1:0] gen     = '0;
  logic [NCH-1:0] ovr_en  = '0;
  logic [NCH-1:0] ovr_val = '0;

  assign pwm_in = (ovr_en & ovr_val) | (~ovr_en & gen);

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      ph[c] = (ph[c] + 1 >= per[c]) ? 0 : ph[c] + 1;
      gen[c] <= (ph[c] >= lowl[c]);
    end
  end

  // Sticky observers of the outputs.
  logic           seen_flag = 1'b0;
  logic [NCH-1:0] seen_stuck = '0, seen_short = '0;

  always @(negedge clk) begin
    if (idle_flag) seen_flag = 1'b1;
    seen_stuck = seen_stuck | ch_stuck;
    seen_short = seen_short | ch_short_low;
  end

  pwm_idle_guard #(
    .NUM_CH(NCH), .CNT_W(CW), .MIN_LOW_CYC(ML), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .timeout_cyc(timeout_cyc),
    .idle_flag(idle_flag), .ch_stuck(ch_stuck), .ch_short_low(ch_short_low)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_seen();
    seen_flag  = 1'b0;
    seen_stuck = '0;
    seen_short = '0;
  endtask

  // Expected-value model from the requirements.
  function automatic bit exp_stuck(input int seg, input int t);
    return seg >= t + 2;          // R2
  endfunction

  function automatic bit exp_short(input int len);
    return len < ML;              // R5 / R6
  endfunction

  // Override one line: low for a samples, high for b samples, low for 4,
  // then hand back to the generator once it is low as well.
  task automatic shape(input int ch, input int a, input int b);
    cyc(1);
    while (gen[ch] !== 1'b1) cyc(1);
    cyc(1);
    ovr_val[ch] = 1'b0;
    ovr_en[ch]  = 1'b1;
    cyc(a);
    ovr_val[ch] = 1'b1;
    cyc(b);
    ovr_val[ch] = 1'b0;
    cyc(4);
    while (gen[ch] !== 1'b0) cyc(1);
    ovr_en[ch] = 1'b0;
  endtask

  // One trial: kind 0 = hold low, 1 = hold high, 2 = short low glitch.
  task automatic trial(input int ch, input int kind, input int len, input string tag);
    bit st, sh;
    chk({tag, " R7 idle before trial"}, idle_flag, 1'b0);
    clear_seen();
    case (kind)
      0:       shape(ch, len, 4);
      1:       shape(ch, 4, len);
      default: shape(ch, len, 4);
    endcase
    st = (kind != 2) && exp_stuck(len, T_NOM);
    sh = (kind == 2) && exp_short(len);
    cyc(8);
    chk({tag, " R4/R5 flag raised"}, seen_flag, st | sh);
    chk({tag, " R2 per-channel stuck"}, seen_stuck, st ? (1 << ch) : 0);
    chk({tag, " R5/R6 short low"}, seen_short, sh ? (1 << ch) : 0);
    cyc(700);
    chk({tag, " R7 recovered"}, idle_flag, 1'b0);
    chk({tag, " R8 stuck dropped"}, ch_stuck, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(2024);
    rst = 1'b1;
    timeout_cyc = CW'(T_NOM);
    ovr_en[1]  = 1'b1;      // channel 1 held low from reset
    ovr_val[1] = 1'b0;
    cyc(5);
    chk("R1 reset flag", idle_flag, 1'b1);
    chk("R1 reset stuck", ch_stuck, 0);
    chk("R1 reset short", ch_short_low, 0);
    rst = 1'b0;
    cyc(1);
    chk("R1 flag after release", idle_flag, 1'b1);

    // R7: only channel 0 toggles, flag must stay up.
    cyc(300);
    chk("R7 one channel silent keeps flag", idle_flag, 1'b1);
    chk("R2 no stuck before limit", ch_stuck, 0);
    while (gen[1] !== 1'b0) cyc(1);
    ovr_en[1] = 1'b0;
    cyc(600);
    chk("R7 flag clears when all toggle", idle_flag, 1'b0);

    // Directed boundaries.
    trial(0, 0, T_NOM + 1, "hold low limit+1");
    trial(1, 1, T_NOM + 2, "hold high limit+2");
    trial(1, 0, T_NOM - 10, "hold low short");
    trial(0, 1, T_NOM + 10, "hold high long");
    trial(0, 2, 2, "glitch 2");
    trial(1, 2, 1, "glitch 1");
    trial(0, 2, ML, "glitch exact");
    trial(1, 2, ML + 1, "glitch wide");

    // R3: shorter limit at run time makes normal frames look idle.
    clear_seen();
    timeout_cyc = CW'(40);
    cyc(400);
    chk("R3 short limit trips", seen_flag, 1'b1);
    chk("R3 short limit both channels", seen_stuck, 2'b11);
    timeout_cyc = CW'(T_NOM);
    cyc(800);
    chk("R3 R7 nominal limit recovers", idle_flag, 1'b0);

    // Random frames and random faults.
    for (int c = 0; c < NCH; c++) begin
      per[c]  = 130 + int'($urandom % 131);
      lowl[c] = 10 + int'($urandom % (per[c] - 20));
    end
    cyc(900);
    for (int n = 0; n < 24; n++) begin
      int ch, kind, len;
      ch   = int'($urandom % NCH);
      kind = int'($urandom % 3);
      if (kind == 2)               len = 1 + int'($urandom % 5);
      else if ($urandom % 2 == 0)  len = 20 + int'($urandom % (T_NOM - 40));
      else                         len = T_NOM + 20 + int'($urandom % 100);
      trial(ch, kind, len, $sformatf("rand%0d", n));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule